// File: doc/BRIEF.md
# Memory clock-change power-down sequencer

This block sits on the controller side of a DDR3-style memory interface and moves the device safely from one stable clock rate to another. When asked for a rate switch it first waits until all banks are reported precharged. It then parks the device in a low-power state: precharge power-down, or self refresh if the configuration input selects that path. Once the device is parked and has been held there long enough, the block hands control to an external clock generator through a two-wire handshake.

When the generator reports that the new clock is running, the block waits for it to settle and then wakes the device. It reissues a mode-register write that resets the DLL, followed by zero to three extra mode-register writes, and waits out the DLL lock time. Only then does it signal completion. Every wait is a count of controller clock cycles, read from configuration inputs that must be held constant while the block is busy. A configured count of 0 behaves as a count of 1.

While the block is busy, the rest of the controller must issue no commands. When the block is idle, the ODT pin simply follows the controller's own ODT request.

Top module: `clkchg_seq`

## Requirements
- R1: A request pulse on `chg_req` seen while idle with `bank_idle` high raises `busy` on the next cycle. If `bank_idle` is low, the request is remembered and is accepted on the cycle after `bank_idle` goes high. A request seen while `busy` is high, including in the `done` cycle, is dropped.
- R2: `odt` is low on every cycle in which `busy` is high. While idle, `odt` equals `odt_in`.
- R3: `cke` falls on the second cycle after acceptance, which leaves one cycle with ODT off and CKE high. In that first CKE-low cycle `cmd` is SRE (2'b10) on the self-refresh path and NOP (2'b00) on the power-down path.
- R4: `change_req` rises max(`cfg_tcksre`,1)+1 cycles after `cke` falls. It is high only while `cke` is low, and it stays high until `clk_stable` rises.
- R5: Only a rising edge of `clk_stable` seen during the change request starts the settle count. `cke` rises max(`cfg_tcksrx`,1)+1 cycles after the cycle in which `clk_stable` is first high. In that first CKE-high cycle `cmd` is SRX (2'b11) on the self-refresh path and NOP on the power-down path.
- R6: The first MRS (2'b01), which carries `mrs_idx`=0 for DLL reset, is issued max(t,1)+1 cycles after `cke` rises. Here t is `cfg_txs` on the self-refresh path and `cfg_txp` on the power-down path.
- R7: After the DLL-reset write, `cfg_mrs_extra` further MRS commands follow with `mrs_idx` 1, 2, … in order. Each comes max(`cfg_tmod`,1)+1 cycles after the previous one.
- R8: `done` is a one-cycle pulse that comes max(`cfg_tmod`,1)+max(`cfg_tdll`,1)+1 cycles after the last MRS. `busy` falls on the cycle after `done`.
- R9: In and right after reset, `cke`=1, `busy`=0, `done`=0, `change_req`=0 and `cmd`=NOP.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Active-low synchronous reset |
| chg_req | input | 1 | Request for a clock-rate switch (pulse or level) |
| use_sr | input | 1 | 1 selects the self-refresh path, 0 the precharge power-down path |
| bank_idle | input | 1 | All banks are precharged and the device may be parked |
| odt_in | input | 1 | ODT request from the normal controller |
| cfg_tcksre | input | CW | Cycles CKE stays low before the clock-change request |
| cfg_tcksrx | input | CW | Cycles of stable new clock before CKE rises |
| cfg_txp | input | CW | Power-down exit to first command |
| cfg_txs | input | CW | Self-refresh exit to first command |
| cfg_tmod | input | CW | Spacing after each mode-register write |
| cfg_tdll | input | CW | DLL lock time |
| cfg_mrs_extra | input | EXW | Number of extra mode-register writes |
| clk_stable | input | 1 | Clock generator reports the new clock is stable |
| cke | output | 1 | Clock enable to the device |
| odt | output | 1 | On-die termination control to the device |
| cmd | output | 2 | 00 NOP, 01 MRS, 10 SRE, 11 SRX |
| mrs_idx | output | EXW | Which mode-register write is being issued (0 = DLL reset) |
| change_req | output | 1 | Request to the clock generator to switch rate |
| busy | output | 1 | Sequence in progress; other command issue is blocked |
| done | output | 1 | One-cycle completion pulse |

## Verification
Two events can land in the same cycle. One is the closing `done` cycle, and the other is a fresh `chg_req`, which must be dropped rather than starting a second switch. The bench drives a request in exactly the cycle where it samples `done` and expects `busy` to stay low for several cycles afterwards. A second pairing is a request arriving while `bank_idle` is low together with the later release of `bank_idle`. The bench checks that `busy` stays low throughout the hold-off and rises exactly one cycle after the release.

// File: rtl/clkchg_pkg.sv
package clkchg_pkg;
  localparam logic [1:0] CMD_NOP = 2'b00;
  localparam logic [1:0] CMD_MRS = 2'b01;
  localparam logic [1:0] CMD_SRE = 2'b10;
  localparam logic [1:0] CMD_SRX = 2'b11;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_ODT_OFF,
    ST_ENTER,
    ST_WSRE,
    ST_CHG,
    ST_WSRX,
    ST_EXIT,
    ST_WXP,
    ST_MRS,
    ST_GAP,
    ST_LOCK,
    ST_DONE
  } seq_state_e;
endpackage

// File: rtl/cc_timer.sv
module cc_timer #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] len,
  output logic         expired
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n)           cnt_q <= '0;
    else if (load)        cnt_q <= len;
    else if (cnt_q != '0) cnt_q <= cnt_q - {{(W-1){1'b0}}, 1'b1};
  end

  assign expired = (cnt_q == '0);
endmodule

// File: rtl/cc_rise.sv
module cc_rise (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic rise
);
  logic d_q;

  always_ff @(posedge clk) begin
    if (!rst_n) d_q <= 1'b1;
    else        d_q <= d;
  end

  assign rise = d & ~d_q;
endmodule

// File: rtl/clkchg_seq.sv
module clkchg_seq
  import clkchg_pkg::*;
#(
  parameter int CW  = 8,
  parameter int EXW = 2
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           chg_req,
  input  logic           use_sr,
  input  logic           bank_idle,
  input  logic           odt_in,
  input  logic [CW-1:0]  cfg_tcksre,
  input  logic [CW-1:0]  cfg_tcksrx,
  input  logic [CW-1:0]  cfg_txp,
  input  logic [CW-1:0]  cfg_txs,
  input  logic [CW-1:0]  cfg_tmod,
  input  logic [CW-1:0]  cfg_tdll,
  input  logic [EXW-1:0] cfg_mrs_extra,
  input  logic           clk_stable,
  output logic           cke,
  output logic           odt,
  output logic [1:0]     cmd,
  output logic [EXW-1:0] mrs_idx,
  output logic           change_req,
  output logic           busy,
  output logic           done
);
  localparam logic [CW-1:0]  ONE_C = {{(CW-1){1'b0}}, 1'b1};
  localparam logic [EXW-1:0] ONE_X = {{(EXW-1){1'b0}}, 1'b1};

  seq_state_e     st_q, st_nx;
  logic           sr_q, pend_q, accept;
  logic [EXW-1:0] ext_q, idx_q;
  logic           tload, texp, stab_rise;
  logic [CW-1:0]  tlen;

  // A stay of n cycles needs a load value of n-1; zero acts as one.
  function automatic logic [CW-1:0] span(input logic [CW-1:0] n);
    return (n == '0) ? '0 : n - ONE_C;
  endfunction

  cc_timer #(.W(CW)) u_timer (
    .clk(clk), .rst_n(rst_n), .load(tload), .len(tlen), .expired(texp)
  );

  cc_rise u_rise (
    .clk(clk), .rst_n(rst_n), .d(clk_stable), .rise(stab_rise)
  );

  assign accept = (st_q == ST_IDLE) && (pend_q || chg_req) && bank_idle;

  always_comb begin
    st_nx = st_q;
    tload = 1'b0;
    tlen  = '0;
    case (st_q)
      ST_IDLE:    if (accept) st_nx = ST_ODT_OFF;
      ST_ODT_OFF: st_nx = ST_ENTER;
      ST_ENTER: begin
        tload = 1'b1;
        tlen  = span(cfg_tcksre);
        st_nx = ST_WSRE;
      end
      ST_WSRE:    if (texp) st_nx = ST_CHG;
      ST_CHG: begin
        if (stab_rise) begin
          tload = 1'b1;
          tlen  = span(cfg_tcksrx);
          st_nx = ST_WSRX;
        end
      end
      ST_WSRX:    if (texp) st_nx = ST_EXIT;
      ST_EXIT: begin
        tload = 1'b1;
        tlen  = span(sr_q ? cfg_txs : cfg_txp);
        st_nx = ST_WXP;
      end
      ST_WXP:     if (texp) st_nx = ST_MRS;
      ST_MRS: begin
        tload = 1'b1;
        tlen  = span(cfg_tmod);
        st_nx = ST_GAP;
      end
      ST_GAP: begin
        if (texp) begin
          if (idx_q == ext_q) begin
            tload = 1'b1;
            tlen  = span(cfg_tdll);
            st_nx = ST_LOCK;
          end else begin
            st_nx = ST_MRS;
          end
        end
      end
      ST_LOCK:    if (texp) st_nx = ST_DONE;
      ST_DONE:    st_nx = ST_IDLE;
      default:    st_nx = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      sr_q   <= 1'b0;
      ext_q  <= '0;
      idx_q  <= '0;
      pend_q <= 1'b0;
    end else begin
      st_q <= st_nx;
      // Held-off requests are remembered only while idle.
      pend_q <= (st_q == ST_IDLE) && (pend_q || chg_req) && !accept;
      if (accept) begin
        sr_q  <= use_sr;
        ext_q <= cfg_mrs_extra;
        idx_q <= '0;
      end else if (st_q == ST_GAP && texp && idx_q != ext_q) begin
        idx_q <= idx_q + ONE_X;
      end
    end
  end

  assign cke = !(st_q inside {ST_ENTER, ST_WSRE, ST_CHG, ST_WSRX});
  assign odt        = odt_in && (st_q == ST_IDLE);
  assign change_req = (st_q == ST_CHG);
  assign busy       = (st_q != ST_IDLE);
  assign done       = (st_q == ST_DONE);
  assign mrs_idx    = idx_q;

  always_comb begin
    cmd = CMD_NOP;
    if (st_q == ST_ENTER && sr_q)     cmd = CMD_SRE;
    else if (st_q == ST_EXIT && sr_q) cmd = CMD_SRX;
    else if (st_q == ST_MRS)          cmd = CMD_MRS;
  end
endmodule

// File: rtl/clkchg_seq_chk.sv
module clkchg_seq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cke,
  input logic       odt,
  input logic [1:0] cmd,
  input logic       change_req,
  input logic       busy,
  input logic       done,
  input logic       clk_stable
);
  a_r2_odt_off_busy: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !odt);

  a_r4_req_while_cke_low: assert property (@(posedge clk) disable iff (!rst_n)
    change_req |-> !cke);

  a_r4_cke_held_after_req: assert property (@(posedge clk) disable iff (!rst_n)
    change_req |=> !cke);

  a_r5_wake_on_stable_clock: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $rose(cke)) |-> clk_stable);

  a_r3_sre_on_cke_fall: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == 2'b10) |-> (!cke && $past(cke)));

  a_r5_srx_on_cke_rise: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == 2'b11) |-> (cke && !$past(cke)));

  a_r6_mrs_awake: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == 2'b01) |-> (cke && busy && !odt));

  a_r8_done_releases: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (!busy && !done));
endmodule

bind clkchg_seq clkchg_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cke(cke), .odt(odt), .cmd(cmd),
  .change_req(change_req), .busy(busy), .done(done), .clk_stable(clk_stable)
);

// File: tb/tb_clkchg_seq.sv
`timescale 1ns/1ps
module tb_clkchg_seq;
  localparam int CW  = 8;
  localparam int EXW = 2;
  localparam logic [1:0] C_NOP = 2'b00, C_MRS = 2'b01, C_SRE = 2'b10, C_SRX = 2'b11;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic chg_req = 1'b0, use_sr = 1'b0, bank_idle = 1'b1, odt_in = 1'b1;
  logic [CW-1:0] cfg_tcksre = '0, cfg_tcksrx = '0, cfg_txp = '0, cfg_txs = '0;
  logic [CW-1:0] cfg_tmod = '0, cfg_tdll = '0;
  logic [EXW-1:0] cfg_mrs_extra = '0;
  logic clk_stable = 1'b1;
  logic cke, odt, change_req, busy, done;
  logic [1:0] cmd;
  logic [EXW-1:0] mrs_idx;

  int checks = 0;
  int failures = 0;

  always #5 clk = ~clk;

  clkchg_seq #(.CW(CW), .EXW(EXW)) dut (
    .clk(clk), .rst_n(rst_n), .chg_req(chg_req), .use_sr(use_sr),
    .bank_idle(bank_idle), .odt_in(odt_in), .cfg_tcksre(cfg_tcksre),
    .cfg_tcksrx(cfg_tcksrx), .cfg_txp(cfg_txp), .cfg_txs(cfg_txs),
    .cfg_tmod(cfg_tmod), .cfg_tdll(cfg_tdll), .cfg_mrs_extra(cfg_mrs_extra),
    .clk_stable(clk_stable), .cke(cke), .odt(odt), .cmd(cmd),
    .mrs_idx(mrs_idx), .change_req(change_req), .busy(busy), .done(done)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int gap(input int n);
    return ((n < 1) ? 1 : n) + 1;
  endfunction

  function automatic int lock_gap(input int tm, input int dl);
    return ((tm < 1) ? 1 : tm) + ((dl < 1) ? 1 : dl) + 1;
  endfunction

  task automatic run_seq(input bit sr, input int tsre, input int tsrx, input int txp,
                         input int txs, input int tmod, input int tdll, input int extra,
                         input int hold, input int sdelay, input bit inj_busy,
                         input bit inj_done);
    int t_busy, t_fall, t_creq, t_stab, t_rise, t_done, n_mrs, stab_cnt;
    int idx_bad, odt_bad, hold_bad, creq_bad, post_bad;
    int fall_cmd, rise_cmd;
    int mrs_t[4];
    bit prev_cke;
    t_busy = -1; t_fall = -1; t_creq = -1; t_stab = -1; t_rise = -1; t_done = -1;
    n_mrs = 0; stab_cnt = -1; idx_bad = 0; odt_bad = 0; hold_bad = 0;
    creq_bad = 0; post_bad = 0; fall_cmd = -1; rise_cmd = -1; prev_cke = 1'b1;
    foreach (mrs_t[i]) mrs_t[i] = -1;

    @(negedge clk);
    use_sr = sr;
    cfg_tcksre = CW'(tsre); cfg_tcksrx = CW'(tsrx); cfg_txp = CW'(txp);
    cfg_txs = CW'(txs); cfg_tmod = CW'(tmod); cfg_tdll = CW'(tdll);
    cfg_mrs_extra = EXW'(extra);
    bank_idle = (hold == 0);
    chg_req = 1'b1;

    for (int t = 1; t < 3000 && t_done < 0; t++) begin
      @(negedge clk);
      chg_req = 1'b0;
      if (busy && t_busy < 0) t_busy = t;
      if (busy && odt) odt_bad++;
      if (change_req && cke) creq_bad++;
      if (prev_cke && !cke && t_fall < 0) begin t_fall = t; fall_cmd = int'(cmd); end
      if (!prev_cke && cke && t_rise < 0) begin t_rise = t; rise_cmd = int'(cmd); end
      if (change_req && t_creq < 0) t_creq = t;
      if (cmd == C_MRS) begin
        if (n_mrs < 4) mrs_t[n_mrs] = t;
        if (int'(mrs_idx) != n_mrs) idx_bad++;
        n_mrs++;
      end
      if (done) t_done = t;
      prev_cke = cke;
      if (hold > 0 && t <= hold && busy) hold_bad++;
      if (hold > 0 && t == hold) bank_idle = 1'b1;
      if (inj_busy && t_busy > 0 && t == t_busy + 3) chg_req = 1'b1;
      if (inj_done && done) chg_req = 1'b1;
      if (change_req && clk_stable) begin
        clk_stable = 1'b0;
        stab_cnt = sdelay;
      end else if (stab_cnt > 0) begin
        stab_cnt--;
      end else if (stab_cnt == 0) begin
        clk_stable = 1'b1;
        t_stab = t;
        stab_cnt = -1;
      end
    end

    for (int k = 0; k < 5; k++) begin
      @(negedge clk);
      chg_req = 1'b0;
      if (busy || done) post_bad++;
      if (odt != odt_in) post_bad++;
    end

    chk(t_busy == ((hold > 0) ? hold + 1 : 1), "R1 busy rise cycle", t_busy,
        (hold > 0) ? hold + 1 : 1);
    chk(hold_bad == 0, "R1 hold-off while bank busy", hold_bad, 0);
    chk(odt_bad == 0, "R2 odt low while busy", odt_bad, 0);
    chk(t_fall == t_busy + 1, "R3 cke fall cycle", t_fall, t_busy + 1);
    chk(fall_cmd == int'(sr ? C_SRE : C_NOP), "R3 entry command", fall_cmd,
        int'(sr ? C_SRE : C_NOP));
    chk(t_creq - t_fall == gap(tsre), "R4 change_req delay", t_creq - t_fall, gap(tsre));
    chk(creq_bad == 0, "R4 change_req only with cke low", creq_bad, 0);
    chk(t_rise - t_stab == gap(tsrx), "R5 cke rise after stable", t_rise - t_stab, gap(tsrx));
    chk(rise_cmd == int'(sr ? C_SRX : C_NOP), "R5 exit command", rise_cmd,
        int'(sr ? C_SRX : C_NOP));
    chk(mrs_t[0] - t_rise == gap(sr ? txs : txp), "R6 DLL reset MRS delay",
        mrs_t[0] - t_rise, gap(sr ? txs : txp));
    chk(n_mrs == extra + 1, "R7 MRS count", n_mrs, extra + 1);
    chk(idx_bad == 0, "R7 MRS index order", idx_bad, 0);
    for (int m = 1; m <= extra && m < 4; m++)
      chk(mrs_t[m] - mrs_t[m-1] == gap(tmod), "R7 MRS spacing",
          mrs_t[m] - mrs_t[m-1], gap(tmod));
    if (extra < 4)
      chk(t_done - mrs_t[extra] == lock_gap(tmod, tdll), "R8 done after lock",
          t_done - mrs_t[extra], lock_gap(tmod, tdll));
    chk(post_bad == 0, "R8 R1 idle after done, late request dropped", post_bad, 0);
  endtask

  initial begin
    #2_000_000;
    failures++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    chk(cke == 1'b1, "R9 reset cke", int'(cke), 1);
    chk(busy == 1'b0 && done == 1'b0, "R9 reset busy/done", int'(busy) + int'(done), 0);
    chk(change_req == 1'b0 && cmd == C_NOP, "R9 reset req/cmd", int'(cmd), 0);
    chg_req = 1'b1;
    @(negedge clk);
    chk(busy == 1'b0, "R9 request ignored in reset", int'(busy), 0);
    chg_req = 1'b0;
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(odt == odt_in, "R2 odt follows odt_in while idle", int'(odt), int'(odt_in));
    odt_in = 1'b0;
    @(negedge clk);
    chk(odt == 1'b0, "R2 odt follows low odt_in", int'(odt), 0);
    odt_in = 1'b1;

    // Directed corner cases.
    run_seq(1'b0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 1'b0, 1'b0);
    run_seq(1'b1, 1, 1, 1, 1, 1, 1, 3, 0, 2, 1'b0, 1'b0);
    run_seq(1'b0, 5, 3, 4, 9, 2, 7, 2, 6, 1, 1'b1, 1'b0);
    run_seq(1'b1, 3, 4, 2, 12, 3, 10, 1, 0, 4, 1'b0, 1'b1);
    run_seq(1'b0, 2, 2, 3, 3, 4, 2, 3, 3, 0, 1'b1, 1'b1);

    // Random mix.
    for (int n = 0; n < 10; n++) begin
      run_seq(1'($urandom_range(0, 1)), $urandom_range(0, 12), $urandom_range(0, 12),
              $urandom_range(0, 10), $urandom_range(0, 30), $urandom_range(0, 8),
              $urandom_range(0, 40), $urandom_range(0, 3), $urandom_range(0, 5),
              $urandom_range(0, 6), 1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)));
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule